// File: doc/BRIEF.md
# Bitfield Extract and Deposit Unit

This block is a 64-bit execution unit for bitfield work. It takes one source value, a field position and an encoded field length, and it carries out one of four operations chosen by a 6-bit function code. Two of the operations pull a field out of the source and sign-extend it to the full word. The other two take the low bits of the source and place them at the field position in a word that is otherwise all zeros. Each kind has a "high" variant whose field position is moved up by 32.

The field length is given as length minus one, so a 5-bit code covers lengths 1 through 32. The result is computed combinationally. A parameter chooses whether one output register follows it, which adds one clock of latency. The default includes the register. An unknown function code gives a zero result and a low valid flag.

Top module: `bitfield_unit`

## Requirements
- R1: Function code 0x3A selects extract, 0x3B extract-high, 0x32 deposit and 0x33 deposit-high. For each of these four codes `valid_o` is 1.
- R2: The field length is `lenm1_i + 1`, so it runs from 1 (code 0) to 32 (code 31).
- R3: Extract returns source bits `pos_i` through `pos_i + length - 1`, sign-extended from the field's top bit to 64 bits.
- R4: Extract-high behaves like extract but starts the field at bit `pos_i + 32`.
- R5: Deposit places the low `length` bits of the source at bit `pos_i`, and every other result bit is 0.
- R6: Deposit-high places the same low source bits at bit `pos_i + 32`, and every other result bit is 0.
- R7: A field that reaches past bit 63 is cut at bit 63 with no error, and `valid_o` stays 1. For extract, the sign is then taken from source bit 63.
- R8: Any other function code gives `valid_o` = 0 and `result_o` = 0.
- R9: With `REG_OUT` = 1 (the default), the outputs appear one rising clock edge after the inputs. While `rst_n` is low, `result_o` is 0 and `valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| func_i | input | 6 | Function code |
| src_i | input | 64 | Source operand |
| pos_i | input | 5 | Field position, before the +32 of the high variants |
| lenm1_i | input | 5 | Field length minus one |
| result_o | output | 64 | Operation result |
| valid_o | output | 1 | High when the function code is one of the four operations |

## Verification
Extract is tried with fields whose top bit is 0 and with fields whose top bit is 1. This separates true sign extension from zero fill, and from extension taken at the wrong bit. Deposit is tried with sources that have ones above the field length, to show that those bits are masked off and never leak past the field. The position and length sweeps cover the extremes: length 1 and length 32, position 0, position 31, and the +32 variants. Fields that run past bit 63 show that truncation is silent. Unknown codes close to the valid ones (0x3C, 0x31, 0x34) show that the decode is exact.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
  localparam int unsigned FUNC_W = 6;

  localparam logic [FUNC_W-1:0] FN_EXTRACT    = 6'h3A;
  localparam logic [FUNC_W-1:0] FN_EXTRACT_HI = 6'h3B;
  localparam logic [FUNC_W-1:0] FN_DEPOSIT    = 6'h32;
  localparam logic [FUNC_W-1:0] FN_DEPOSIT_HI = 6'h33;

  typedef enum logic [1:0] {
    KIND_NONE    = 2'd0,
    KIND_EXTRACT = 2'd1,
    KIND_DEPOSIT = 2'd2
  } bf_kind_e;

  typedef struct packed {
    logic     valid;
    logic     high;
    bf_kind_e kind;
  } bf_decode_t;
endpackage

// File: rtl/bfu_decode.sv
module bfu_decode
  import bfu_pkg::*;
(
  input  logic [FUNC_W-1:0] func_i,
  output bf_decode_t        dec_o
);
  always_comb begin
    dec_o = '{valid: 1'b0, high: 1'b0, kind: KIND_NONE};
    unique case (func_i)
      FN_EXTRACT:    dec_o = '{valid: 1'b1, high: 1'b0, kind: KIND_EXTRACT};
      FN_EXTRACT_HI: dec_o = '{valid: 1'b1, high: 1'b1, kind: KIND_EXTRACT};
      FN_DEPOSIT:    dec_o = '{valid: 1'b1, high: 1'b0, kind: KIND_DEPOSIT};
      FN_DEPOSIT_HI: dec_o = '{valid: 1'b1, high: 1'b1, kind: KIND_DEPOSIT};
      default:       dec_o = '{valid: 1'b0, high: 1'b0, kind: KIND_NONE};
    endcase
  end
endmodule

// File: rtl/bfu_extract.sv
module bfu_extract #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned SH_W   = 6,
  parameter int unsigned LEN_W  = 6
) (
  input  logic [DATA_W-1:0] src_i,
  input  logic [SH_W-1:0]   pos_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [DATA_W-1:0] res_o
);
  // Shifting right arithmetically by pos keeps bit 63's sign when the field
  // is cut off at the top, so sign-extending from bit len-1 afterwards gives
  // the right result in both cases.
  function automatic logic [DATA_W-1:0] sext_field(
    input logic [DATA_W-1:0] src,
    input int                pos,
    input int                len
  );
    logic signed [DATA_W-1:0] t;
    t = $signed(src) >>> pos;
    t = t <<< (DATA_W - len);
    t = t >>> (DATA_W - len);
    return t;
  endfunction

  assign res_o = sext_field(src_i, int'(pos_i), int'(len_i));
endmodule

// File: rtl/bfu_deposit.sv
module bfu_deposit #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned SH_W   = 6,
  parameter int unsigned LEN_W  = 6
) (
  input  logic [DATA_W-1:0] src_i,
  input  logic [SH_W-1:0]   pos_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [DATA_W-1:0] res_o
);
  function automatic logic [DATA_W-1:0] place_low(
    input logic [DATA_W-1:0] src,
    input int                pos,
    input int                len
  );
    logic [DATA_W-1:0] low_mask;
    low_mask = {DATA_W{1'b1}} >> (DATA_W - len);
    return (src & low_mask) << pos;
  endfunction

  assign res_o = place_low(src_i, int'(pos_i), int'(len_i));
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
  import bfu_pkg::*;
#(
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned POS_W   = 5,
  parameter int unsigned LENM1_W = 5,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [FUNC_W-1:0]    func_i,
  input  logic [DATA_W-1:0]    src_i,
  input  logic [POS_W-1:0]     pos_i,
  input  logic [LENM1_W-1:0]   lenm1_i,
  output logic [DATA_W-1:0]    result_o,
  output logic                 valid_o
);
  localparam int unsigned SH_W  = $clog2(DATA_W);
  localparam int unsigned LEN_W = LENM1_W + 1;
  localparam int unsigned HALF  = DATA_W / 2;

  bf_decode_t         dec;
  logic [SH_W-1:0]    pos_eff;
  logic [LEN_W-1:0]   fld_len;
  logic [DATA_W-1:0]  ext_res;
  logic [DATA_W-1:0]  dep_res;
  logic [DATA_W-1:0]  comb_result;
  logic               comb_valid;

  bfu_decode i_decode (
    .func_i (func_i),
    .dec_o  (dec)
  );

  assign pos_eff = dec.high ? SH_W'(pos_i) + SH_W'(HALF) : SH_W'(pos_i);
  assign fld_len = {1'b0, lenm1_i} + LEN_W'(1);

  bfu_extract #(.DATA_W(DATA_W), .SH_W(SH_W), .LEN_W(LEN_W)) i_extract (
    .src_i (src_i),
    .pos_i (pos_eff),
    .len_i (fld_len),
    .res_o (ext_res)
  );

  bfu_deposit #(.DATA_W(DATA_W), .SH_W(SH_W), .LEN_W(LEN_W)) i_deposit (
    .src_i (src_i),
    .pos_i (pos_eff),
    .len_i (fld_len),
    .res_o (dep_res)
  );

  always_comb begin
    unique case (dec.kind)
      KIND_EXTRACT: comb_result = ext_res;
      KIND_DEPOSIT: comb_result = dep_res;
      default:      comb_result = '0;
    endcase
  end
  assign comb_valid = dec.valid;

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          result_o <= '0;
          valid_o  <= 1'b0;
        end else begin
          result_o <= comb_result;
          valid_o  <= comb_valid;
        end
      end

      // R9: registered outputs follow the combinational result one edge later
      a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (result_o == $past(comb_result) && valid_o == $past(comb_valid)));

      // R1: valid output only for one of the four function codes
      a_r1_valid_codes: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (!valid_o || $past(func_i) == FN_EXTRACT || $past(func_i) == FN_EXTRACT_HI
                  || $past(func_i) == FN_DEPOSIT || $past(func_i) == FN_DEPOSIT_HI));

      // R8: an invalid result at the ports is always zero
      a_r8_invalid_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> result_o == '0);
    end else begin : g_comb
      assign result_o = comb_result;
      assign valid_o  = comb_valid;
    end
  endgenerate

  // Observation wires for the assertions below
  logic [DATA_W-1:0]        win_mask;
  logic [DATA_W-1:0]        low_mask;
  logic signed [DATA_W-1:0] ext_upper;
  assign low_mask  = {DATA_W{1'b1}} >> (DATA_W - int'(fld_len));
  assign win_mask  = low_mask << pos_eff;
  assign ext_upper = $signed(ext_res) >>> (int'(fld_len) - 1);

  // R5/R6: deposit leaves every bit outside the field window at zero
  a_r5_deposit_outside: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.kind == KIND_DEPOSIT) |-> (dep_res & ~win_mask) == '0);

  // R3: extract bits above the field top are copies of one sign
  a_r3_extract_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.kind == KIND_EXTRACT) |-> (ext_upper == '0 || ext_upper == '1));

  // R3/R7: extracted field bits that lie inside the word match the source
  a_r3_extract_field: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.kind == KIND_EXTRACT) |->
      ((ext_res ^ (src_i >> pos_eff)) & low_mask & ({DATA_W{1'b1}} >> pos_eff)) == '0);
endmodule

// File: tb/test_bitfield_unit.sv
module test_bitfield_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  func_i = '0;
  logic [63:0] src_i = '0;
  logic [4:0]  pos_i = '0;
  logic [4:0]  lenm1_i = '0;
  logic [63:0] result_o;
  logic        valid_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  bitfield_unit i_bitfield_unit (
    .clk(clk), .rst_n(rst_n), .func_i(func_i), .src_i(src_i),
    .pos_i(pos_i), .lenm1_i(lenm1_i), .result_o(result_o), .valid_o(valid_o)
  );

  // Bit-by-bit reference, written from the requirements
  function automatic logic [63:0] model(input logic [5:0] f, input logic [63:0] s,
                                        input int p, input int lm1, output logic v);
    logic [63:0] r = '0;
    int pos = p;
    int len = lm1 + 1;
    v = 1'b1;
    if (f == 6'h3B || f == 6'h33) pos = p + 32;
    if (f == 6'h3A || f == 6'h3B) begin
      for (int i = 0; i < 64; i++) begin
        int k = (i < len) ? i : len - 1;
        int idx = pos + k;
        if (idx > 63) idx = 63;
        r[i] = s[idx];
      end
    end else if (f == 6'h32 || f == 6'h33) begin
      for (int i = 0; i < 64; i++)
        if (i >= pos && i - pos < len) r[i] = s[i - pos];
    end else begin
      v = 1'b0;
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Apply one operation, wait one edge for the output register, compare
  task automatic run_op(input string tag, input logic [5:0] f, input logic [63:0] s,
                        input int p, input int lm1);
    logic [63:0] er;
    logic ev;
    er = model(f, s, p, lm1, ev);
    @(negedge clk);
    func_i = f; src_i = s; pos_i = 5'(p); lenm1_i = 5'(lm1);
    @(negedge clk);
    check(tag, result_o, er);
    check({tag, " valid"}, {63'd0, valid_o}, {63'd0, ev});
  endtask

  task automatic t_reset();
    func_i = 6'h3A; src_i = '1; pos_i = 0; lenm1_i = 5'd31;
    repeat (2) @(negedge clk);
    check("R9 reset result", result_o, 64'd0);
    check("R9 reset valid", {63'd0, valid_o}, 64'd0);
    rst_n = 1'b1;
  endtask

  task automatic t_extract();
    run_op("R3 extract neg", 6'h3A, 64'h0000_0000_0000_F000, 12, 3);
    check("R3 extract neg literal", result_o, 64'hFFFF_FFFF_FFFF_FFFF);
    run_op("R3 extract pos", 6'h3A, 64'h0000_0000_0000_7000, 12, 3);
    check("R3 extract pos literal", result_o, 64'h7);
    run_op("R3 extract mid", 6'h3A, 64'h1234_5678_9ABC_DEF0, 8, 15);
    run_op("R2 extract len1", 6'h3A, 64'h0000_0000_8000_0000, 31, 0);
    check("R2 len1 literal", result_o, 64'hFFFF_FFFF_FFFF_FFFF);
    run_op("R2 extract len32", 6'h3A, 64'h0000_0000_8765_4321, 0, 31);
    check("R2 len32 literal", result_o, 64'hFFFF_FFFF_8765_4321);
  endtask

  task automatic t_extract_hi();
    run_op("R4 extract hi", 6'h3B, 64'h00AB_0000_0000_0000, 16, 7);
    check("R4 extract hi literal", result_o, 64'hFFFF_FFFF_FFFF_FFAB);
    run_op("R4 extract hi pos", 6'h3B, 64'h0000_0005_FFFF_FFFF, 0, 3);
    check("R4 extract hi pos literal", result_o, 64'h5);
  endtask

  task automatic t_deposit();
    run_op("R5 deposit", 6'h32, 64'hFFFF_FFFF_FFFF_FFFF, 4, 3);
    check("R5 deposit literal", result_o, 64'hF0);
    run_op("R5 deposit mid", 6'h32, 64'hDEAD_BEEF_CAFE_1234, 20, 15);
    run_op("R2 deposit len32", 6'h32, 64'hFFFF_FFFF_0000_0001, 0, 31);
    check("R2 deposit len32 literal", result_o, 64'h1);
  endtask

  task automatic t_deposit_hi();
    run_op("R6 deposit hi", 6'h33, 64'hFFFF_FFFF_FFFF_FFA5, 8, 7);
    check("R6 deposit hi literal", result_o, 64'h0000_A500_0000_0000);
    run_op("R6 deposit hi pos0", 6'h33, 64'h3, 0, 0);
    check("R6 deposit hi pos0 literal", result_o, 64'h0000_0001_0000_0000);
  endtask

  task automatic t_truncate();
    run_op("R7 extract cut", 6'h3B, 64'h8000_0000_0000_0000, 31, 31);
    check("R7 extract cut literal", result_o, 64'hFFFF_FFFF_FFFF_FFFF);
    run_op("R7 extract cut pos", 6'h3B, 64'h4000_0000_0000_0000, 30, 31);
    check("R7 extract cut pos literal", result_o, 64'h1);
    run_op("R7 deposit cut", 6'h33, 64'hFFFF_FFFF_FFFF_FFFF, 28, 31);
    check("R7 deposit cut literal", result_o, 64'hF000_0000_0000_0000);
  endtask

  task automatic t_invalid();
    run_op("R8 code 3C", 6'h3C, 64'hFFFF_FFFF_FFFF_FFFF, 3, 5);
    run_op("R8 code 31", 6'h31, 64'h1234_1234_1234_1234, 0, 31);
    run_op("R8 code 34", 6'h34, 64'hFFFF_0000_FFFF_0000, 7, 7);
    run_op("R1 back to valid", 6'h3A, 64'hFF, 0, 7);
  endtask

  task automatic t_sweep();
    logic [63:0] s = 64'h9E37_79B9_7F4A_7C15;
    for (int n = 0; n < 48; n++) begin
      logic [5:0] f;
      case (n % 4)
        0: f = 6'h3A;
        1: f = 6'h3B;
        2: f = 6'h32;
        default: f = 6'h33;
      endcase
      s = {s[62:0], s[63] ^ s[62] ^ s[60] ^ s[59]};
      run_op("R1 sweep", f, s, (n * 7) % 32, (n * 13) % 32);
    end
  endtask

  initial begin
    t_reset();
    t_extract();
    t_extract_hi();
    t_deposit();
    t_deposit_hi();
    t_truncate();
    t_invalid();
    t_sweep();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule